// File: doc/BRIEF.md
# Timing Skew Delay-Code Controller

This controller closes the adaptation loop of a four-way interleaved sampler. Each time the skew detector finishes a measurement block, it presents four signed adjacent-pair skew errors on one `err_vld` pulse. The controller forms their rounded average and subtracts it from each error. This cancels a bias that is common to all four. It then integrates each remaining residual over a fixed number of updates. When a window closes, it moves a saturating signed delay code by one step up, by one step down or not at all.

Three codes leave the block, one each for channels 2, 3 and 4. Each code feeds an external programmable delay line, and one LSB of the code is one delay step. Channel 1 is the timing reference and has no code. The first pair error affects the loop only through the average. An enable input holds the whole loop still. A synchronous clear puts it back to its starting point.

Top module: `skew_lms_ctrl`

## Requirements
- R1: After reset, all three delay codes read 0 and the window counter and integrators are empty.
- R2: On each accepted update the average is m = (e1+e2+e3+e4+2) >>> 2, an arithmetic shift that rounds half upward. Residual k is ek − m.
- R3: Each integrator adds its residual on every accepted update. On the WIN-th accepted update of a window, the step is +1 if the total including that update is strictly above THR, −1 if it is strictly below −THR, and 0 otherwise. The integrator then restarts from zero.
- R4: The step taken from residual k (k = 2, 3, 4) moves code k (`dly2`, `dly3`, `dly4`). The residual of e1 moves no code; e1 acts only through the average.
- R5: The codes are CW-bit two's complement and saturate at +127 and −128 (CW = 8) instead of wrapping.
- R6: While `en` is low, updates are ignored. Codes, integrators and the window counter keep their values.
- R7: A high `clr` on a clock edge zeroes the codes, integrators and window counter. This holds whatever the state of `en`, and `clr` wins over a window end in the same cycle.
- R8: A cycle with `err_vld` low changes nothing.
- R9: No code moves by more than one LSB on any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Adaptation enable; low freezes all state |
| clr | input | 1 | Synchronous clear of codes, integrators and counter |
| err_vld | input | 1 | One-cycle strobe marking a new set of pair errors |
| err1 | input | EW | Signed skew error of pair 1 (reference side) |
| err2 | input | EW | Signed skew error of pair 2 |
| err3 | input | EW | Signed skew error of pair 3 |
| err4 | input | EW | Signed skew error of pair 4 |
| dly2 | output | CW | Signed delay code, channel 2 |
| dly3 | output | CW | Signed delay code, channel 3 |
| dly4 | output | CW | Signed delay code, channel 4 |

## Verification
A clear can arrive on the same edge as the update that closes a window. The bench provokes this by feeding three updates that would each drive a code past the threshold, then sending the fourth update together with `clr`. It judges the outcome by reading zero codes afterwards. It also checks that exactly WIN further updates are needed before the next step appears, which shows that the counter was cleared too. A second collision, between a saturated code and a step in the same direction, is driven by running the codes into both limits and reading them after further windows.

// File: rtl/skew_lms_ctrl.sv
module skew_lms_ctrl #(
  parameter int EW  = 12,
  parameter int CW  = 8,
  parameter int WIN = 4,
  parameter int THR = 100
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 clr,
  input  logic                 err_vld,
  input  logic signed [EW-1:0] err1,
  input  logic signed [EW-1:0] err2,
  input  logic signed [EW-1:0] err3,
  input  logic signed [EW-1:0] err4,
  output logic signed [CW-1:0] dly2,
  output logic signed [CW-1:0] dly3,
  output logic signed [CW-1:0] dly4
);

  localparam int SW   = EW + 2;
  localparam int CNTW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam int AW   = SW + CNTW + 1;
  localparam logic signed [CW-1:0] CMAX = {1'b0, {(CW-1){1'b1}}};
  localparam logic signed [CW-1:0] CMIN = {1'b1, {(CW-1){1'b0}}};

  logic signed [SW-1:0] tot, mean;
  logic signed [SW-1:0] res [4];
  logic [CNTW-1:0] cnt;
  logic take, last;

  assign take = en && err_vld;
  assign last = (cnt == CNTW'(WIN - 1));
  assign tot  = SW'(err1) + SW'(err2) + SW'(err3) + SW'(err4);
  assign mean = (tot + SW'(2)) >>> 2;
  assign res[0] = SW'(err1) - mean;
  assign res[1] = SW'(err2) - mean;
  assign res[2] = SW'(err3) - mean;
  assign res[3] = SW'(err4) - mean;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (take)  cnt <= last ? '0 : cnt + 1'b1;
  end

  for (genvar k = 0; k < 3; k++) begin : g_ch
    logic signed [AW-1:0] acc, nxt;
    logic signed [CW-1:0] code;
    logic up, dn;

    assign nxt = acc + AW'(res[k+1]);
    assign up  = last && (nxt > THR);
    assign dn  = last && (nxt < -THR);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc  <= '0;
        code <= '0;
      end else if (clr) begin
        acc  <= '0;
        code <= '0;
      end else if (take) begin
        acc <= last ? '0 : nxt;
        if (up && code != CMAX)      code <= code + 1'b1;
        else if (dn && code != CMIN) code <= code - 1'b1;
      end
    end
  end

  assign dly2 = g_ch[0].code;
  assign dly3 = g_ch[1].code;
  assign dly4 = g_ch[2].code;

endmodule

// File: rtl/skew_lms_ctrl_chk.sv
module skew_lms_ctrl_chk #(
  parameter int CW = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 en,
  input logic                 clr,
  input logic                 err_vld,
  input logic signed [CW-1:0] dly2,
  input logic signed [CW-1:0] dly3,
  input logic signed [CW-1:0] dly4
);

  localparam logic signed [CW-1:0] CMAX = {1'b0, {(CW-1){1'b1}}};
  localparam logic signed [CW-1:0] CMIN = {1'b1, {(CW-1){1'b0}}};

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (dly2 == 0 && dly3 == 0 && dly4 == 0)); // R7

  AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> ($stable(dly2) && $stable(dly3) && $stable(dly4))); // R6

  AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_vld && !clr) |=> ($stable(dly2) && $stable(dly3) && $stable(dly4))); // R8

  AST_ONE_LSB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((int'(dly2) - int'($past(dly2))) <= 1 && (int'(dly2) - int'($past(dly2))) >= -1 &&
              (int'(dly3) - int'($past(dly3))) <= 1 && (int'(dly3) - int'($past(dly3))) >= -1 &&
              (int'(dly4) - int'($past(dly4))) <= 1 && (int'(dly4) - int'($past(dly4))) >= -1)); // R9

  AST_NO_WRAP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (dly2 == CMAX && !clr) |=> dly2 != CMIN); // R5

  AST_NO_WRAP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (dly3 == CMIN && !clr) |=> dly3 != CMAX); // R5

endmodule

bind skew_lms_ctrl skew_lms_ctrl_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .clr(clr), .err_vld(err_vld),
  .dly2(dly2), .dly3(dly3), .dly4(dly4)
);

// File: tb/sim_skew_lms_ctrl.sv
module sim_skew_lms_ctrl;
  localparam int EW = 12, CW = 8, WIN = 4, THR = 100;

  // e1, e2, e3, e4, expected dly2, dly3, dly4 after one full window
  localparam int VEC [4][7] = '{
    '{0,   40, -40,  0, 1, -1,  0},   // R3 plain steps
    '{10,  30, -30, 10, 1, -2,  0},   // R3 total exactly THR gives no step
    '{2,   26, -26,  0, 1, -3,  0},   // R2 rounding of mean decides
    '{400,  0,   0,  0, 0, -4, -1}    // R4 e1 acts only via mean
  };

  logic clk = 0, rst_n = 0, en = 0, clr = 0, err_vld = 0;
  logic signed [EW-1:0] e1 = 0, e2 = 0, e3 = 0, e4 = 0;
  logic signed [CW-1:0] d2, d3, d4;
  int nchk = 0, nbad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  skew_lms_ctrl #(.EW(EW), .CW(CW), .WIN(WIN), .THR(THR)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .clr(clr), .err_vld(err_vld),
    .err1(e1), .err2(e2), .err3(e3), .err4(e4),
    .dly2(d2), .dly3(d3), .dly4(d4)
  );

  task automatic upd(input int a1, a2, a3, a4, input bit c = 0);
    @(negedge clk);
    e1 = a1; e2 = a2; e3 = a3; e4 = a4; err_vld = 1; clr = c;
    @(negedge clk);
    err_vld = 0; clr = 0;
  endtask

  task automatic chk(input string rq, input int x2, x3, x4);
    nchk++;
    if (d2 !== x2 || d3 !== x3 || d4 !== x4) begin
      nbad++;
      $display("FAIL %s: got %0d %0d %0d expected %0d %0d %0d", rq, d2, d3, d4, x2, x3, x4);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", 0, 0, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", 0, 0, 0);
    en = 1;

    for (int v = 0; v < 4; v++) begin
      for (int u = 0; u < WIN; u++) upd(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
      chk("R2/R3/R4 vector", VEC[v][4], VEC[v][5], VEC[v][6]);
    end

    // R8: idle cycles with valid low
    repeat (5) @(negedge clk);
    chk("R8", 0, -4, -1);

    // R7: clear, then R5 saturation at both limits
    upd(0, 0, 0, 0, 1);
    chk("R7", 0, 0, 0);
    for (int w = 0; w < 135 * WIN; w++) upd(0, 1000, -1000, 0);
    chk("R5", 127, -128, 0);

    // R6: clear works with en low, then en low ignores updates
    en = 0;
    upd(0, 0, 0, 0, 1);
    chk("R7 en low", 0, 0, 0);
    for (int u = 0; u < WIN; u++) upd(0, 1000, -1000, 0);
    chk("R6", 0, 0, 0);
    en = 1;
    for (int u = 0; u < WIN - 1; u++) upd(0, 1000, -1000, 0);
    chk("R6 counter held", 0, 0, 0);
    upd(0, 1000, -1000, 0);
    chk("R6/R3 window end", 1, -1, 0);

    // R7: clear collides with window end
    for (int u = 0; u < WIN - 1; u++) upd(0, 1000, 1000, -2000);
    upd(0, 1000, 1000, -2000, 1);
    chk("R7 collision", 0, 0, 0);
    for (int u = 0; u < WIN - 1; u++) upd(0, 1000, 1000, -2000);
    chk("R7 counter cleared", 0, 0, 0);
    upd(0, 1000, 1000, -2000);
    chk("R7/R9 next window", 1, 1, -1);

    // R3: integrator restarts after a window
    for (int u = 0; u < WIN; u++) upd(0, 24, -24, 0);
    chk("R3 restart", 1, 1, -1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    for (int t = 0; t < 150000; t++) @(posedge clk);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end
endmodule